// File: doc/BRIEF.md
# Two-Stage Parallel Output Register with Direct Mode

This block receives an 8-bit parallel write from a microcontroller and drives eight output-enable bits, one per channel. A write is a two-step affair: while the chip select and the write strobe are both low, the data bus is captured into a staging register. The staging register stops following the bus when the write strobe goes high. A later rising edge of chip select then moves the staged value into the output register that drives the channels. Several such blocks can share one data bus and one write strobe, each with its own chip select, so that data is staged in every part before it is committed.

A second way of use needs no strobes. If chip select and the write strobe are both held low for longer than any legal write pulse, the block goes transparent and the synchronised data bus drives the channels directly. The active-low disable input forces every channel off at once, without waiting for the clock, and wipes both registers. The channels then stay off until new data has been written and committed. All strobe and data pins are brought into the internal clock domain through two-flop synchronisers before any edge is detected.

Top module: `par_out_latch`

## Requirements
- R1: After reset every bit of `out_en` is 0.
- R2: While `cs_n` and `wr_n` are both low (after synchronisation), `data` is captured into the staging register. A write without a following chip-select rise leaves `out_en` unchanged.
- R3: Changes on `data` after `wr_n` has gone high do not alter the staged value. A later commit shows the value present while `wr_n` was low.
- R4: Bit i of `data` controls bit i of `out_en` for every i in 0..W-1, with no reordering.
- R5: A low-to-high transition of `cs_n` copies the staging register into the output register. At no other time does the output register change, except when it is cleared.
- R6: Once `cs_n` and `wr_n` have both been low for DIRECT_CYC consecutive synchronised cycles, `out_en` equals the synchronised `data`, two clock cycles behind the pins.
- R7: A period of both strobes low that is shorter than DIRECT_CYC cycles does not make the outputs transparent, and `out_en` keeps its committed value.
- R8: Transparent mode ends as soon as either strobe goes high. `out_en` then shows the output register again.
- R9: When `dis_n` goes low, all bits of `out_en` go to 0 without a clock edge, and the staging register and output register are cleared.
- R10: After `dis_n` returns high, `out_en` stays 0 until a new write has been captured and committed. A chip-select pulse with no write commits zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock, much faster than the strobes |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low chip select; its rising edge commits staged data |
| wr_n | input | 1 | Active-low write strobe; captures data while low with cs_n low |
| data | input | W | Parallel data bus; bit i drives channel i |
| dis_n | input | 1 | Asynchronous active-low disable; forces outputs off and clears registers |
| out_en | output | W | Channel enable outputs |

## Verification
The assertions assume that the strobes and data obey the interface timing as seen in clock cycles: data is stable while both strobes are low and set up together with the write strobe, and the write strobe returns high before chip select does. The bench drives every pin on the falling clock edge and holds each level for at least two cycles. It changes data only while the write strobe is high or while in transparent mode, and it keeps write pulses well under DIRECT_CYC cycles except where transparent mode is the aim. The disable input is the only signal that is changed without regard to the clock, and the checks on it make no assumption about its timing.

// File: rtl/pol_pkg.sv
package pol_pkg;
  typedef enum logic {
    MODE_LATCHED = 1'b0,
    MODE_DIRECT  = 1'b1
  } pol_mode_e;
endpackage

// File: rtl/pol_rst_sync.sv
// Asynchronous assert, two-flop synchronous release.
module pol_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/pol_sync.sv
// Two-flop synchroniser for a bus of independent bits.
module pol_sync #(
  parameter int        W       = 1,
  parameter logic      RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= {W{RST_VAL}};
      sync_q <= {W{RST_VAL}};
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/pol_strobe_ctrl.sv
// Edge detection on chip select and the dwell counter for transparent mode.
module pol_strobe_ctrl
  import pol_pkg::*;
#(
  parameter int DIRECT_CYC = 16
) (
  input  logic      clk,
  input  logic      clr_n,
  input  logic      s_cs_n,
  input  logic      s_wr_n,
  output logic      load_en,
  output logic      commit,
  output pol_mode_e mode
);
  localparam int            CW  = $clog2(DIRECT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(DIRECT_CYC);

  logic          cs_prev_q, cs_prev_d;
  logic [CW-1:0] dwell_q, dwell_d;
  logic          both_low;

  assign both_low = !s_cs_n && !s_wr_n;

  always_comb begin
    cs_prev_d = s_cs_n;
    if (!both_low)          dwell_d = '0;
    else if (dwell_q < LIM) dwell_d = dwell_q + 1'b1;
    else                    dwell_d = dwell_q;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cs_prev_q <= 1'b1;
      dwell_q   <= '0;
    end else begin
      cs_prev_q <= cs_prev_d;
      dwell_q   <= dwell_d;
    end
  end

  assign load_en = both_low;
  assign commit  = s_cs_n && !cs_prev_q;
  assign mode    = (both_low && dwell_q == LIM) ? MODE_DIRECT : MODE_LATCHED;
endmodule

// File: rtl/pol_latch_pair.sv
// Staging register and output register, both cleared by clr_n.
module pol_latch_pair #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_en,
  input  logic         commit,
  input  logic [W-1:0] din,
  output logic [W-1:0] in_lat,
  output logic [W-1:0] out_reg
);
  logic [W-1:0] stage_q, stage_d;
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    stage_d = load_en ? din : stage_q;
    hold_d  = commit ? stage_q : hold_q;
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      stage_q <= '0;
      hold_q  <= '0;
    end else begin
      stage_q <= stage_d;
      hold_q  <= hold_d;
    end
  end

  assign in_lat  = stage_q;
  assign out_reg = hold_q;
endmodule

// File: rtl/par_out_latch.sv
module par_out_latch
  import pol_pkg::*;
#(
  parameter int W          = 8,
  parameter int DIRECT_CYC = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         wr_n,
  input  logic [W-1:0] data,
  input  logic         dis_n,
  output logic [W-1:0] out_en
);
  logic         rs_n;
  logic         clr_n;
  logic         s_cs_n, s_wr_n;
  logic [W-1:0] s_data;
  logic         load_en, commit, direct;
  pol_mode_e    mode;
  logic [W-1:0] in_lat, out_reg;

  pol_rst_sync u_rst_sync (.clk(clk), .arst_n(rst_n), .srst_n(rs_n));
  pol_rst_sync u_clr_sync (.clk(clk), .arst_n(rst_n & dis_n), .srst_n(clr_n));

  pol_sync #(.W(2), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rs_n), .d({cs_n, wr_n}), .q({s_cs_n, s_wr_n})
  );

  pol_sync #(.W(W), .RST_VAL(1'b0)) u_data_sync (
    .clk(clk), .rst_n(rs_n), .d(data), .q(s_data)
  );

  pol_strobe_ctrl #(.DIRECT_CYC(DIRECT_CYC)) u_ctrl (
    .clk(clk), .clr_n(clr_n), .s_cs_n(s_cs_n), .s_wr_n(s_wr_n),
    .load_en(load_en), .commit(commit), .mode(mode)
  );

  pol_latch_pair #(.W(W)) u_regs (
    .clk(clk), .clr_n(clr_n), .load_en(load_en), .commit(commit),
    .din(s_data), .in_lat(in_lat), .out_reg(out_reg)
  );

  assign direct = (mode == MODE_DIRECT);

  for (genvar i = 0; i < W; i++) begin : g_chan
    assign out_en[i] = clr_n & (direct ? s_data[i] : out_reg[i]);
  end
endmodule

// File: rtl/pol_chk.sv
module pol_chk #(
  parameter int W          = 8,
  parameter int DIRECT_CYC = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dis_n,
  input logic         clr_n,
  input logic         s_cs_n,
  input logic         s_wr_n,
  input logic [W-1:0] s_data,
  input logic         commit,
  input logic         direct,
  input logic [W-1:0] in_lat,
  input logic [W-1:0] out_reg,
  input logic [W-1:0] out_en
);
  localparam int CW = $clog2(DIRECT_CYC + 2);
  logic [CW-1:0] low_run_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)                 low_run_q <= '0;
    else if (s_cs_n || s_wr_n)  low_run_q <= '0;
    else if (low_run_q < CW'(DIRECT_CYC)) low_run_q <= low_run_q + 1'b1;
  end

  // R9
  dis_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |-> (out_en == '0 && in_lat == '0 && out_reg == '0));

  // R5
  commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && clr_n) |=> (out_reg == $past(in_lat)) || !clr_n);

  // R5
  out_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && clr_n) |=> (out_reg == $past(out_reg)) || !clr_n);

  // R3
  stage_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((s_cs_n || s_wr_n) && clr_n) |=> (in_lat == $past(in_lat)) || !clr_n);

  // R6
  direct_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct |-> out_en == s_data);

  // R7
  direct_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct |-> low_run_q >= CW'(DIRECT_CYC));

  // R8
  direct_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct |-> (!s_cs_n && !s_wr_n));
endmodule

bind par_out_latch pol_chk #(.W(W), .DIRECT_CYC(DIRECT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .dis_n(dis_n), .clr_n(clr_n),
  .s_cs_n(s_cs_n), .s_wr_n(s_wr_n), .s_data(s_data), .commit(commit),
  .direct(direct), .in_lat(in_lat), .out_reg(out_reg), .out_en(out_en)
);

// File: tb/par_out_latch_tb.sv
module par_out_latch_tb;
  localparam int CLK_P = 10;
  localparam int W     = 8;
  localparam int DCYC  = 16;

  logic         clk = 1'b0;
  logic         rst_n, cs_n, wr_n, dis_n;
  logic [W-1:0] data;
  logic [W-1:0] out_en;
  logic [W-1:0] committed;
  int           n_chk  = 0;
  int           n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  par_out_latch #(.W(W), .DIRECT_CYC(DCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .data(data), .dis_n(dis_n), .out_en(out_en)
  );

  task automatic chk(input string tag, input logic [W-1:0] exp);
    n_chk++;
    if (out_en !== exp) begin
      n_fail++;
      $display("FAIL %s: out_en=%02h expected=%02h", tag, out_en, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Stage d with a write pulse of wlen cycles, disturb the bus, then commit.
  task automatic write_commit(input logic [W-1:0] d, input int wlen, input string tag);
    cs_n = 1'b0; cyc(2);
    data = d; wr_n = 1'b0; cyc(wlen);
    wr_n = 1'b1; cyc(2);
    data = ~d; cyc(4);
    chk({tag, " R2 no change before commit"}, committed);
    cs_n = 1'b1; cyc(5);
    committed = d;
    chk({tag, " R3/R5 committed value"}, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: out_en=%02h expected=done", out_en);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; dis_n = 1'b1; data = '0;
    committed = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 reset state", '0);

    // R4: walking one on each channel
    for (int i = 0; i < W; i++) begin
      write_commit(W'(1) << i, 3, "R4 walking one");
    end

    // R2 R3: full sweep of data values with varying short write pulses
    for (int v = 0; v < 256; v++) begin
      write_commit(W'(v), 2 + (v % (DCYC - 6)), "R2 sweep");
    end

    // R7: both strobes low for less than DIRECT_CYC cycles, no transparency
    for (int k = 1; k < DCYC - 3; k++) begin
      cs_n = 1'b0; wr_n = 1'b0; data = ~committed; cyc(k);
      chk("R7 short low period", committed);
      wr_n = 1'b1; cyc(3);
      chk("R7 after short low period", committed);
      cs_n = 1'b1; cyc(5);
      committed = ~committed;
      chk("R5 commit after short pulse", committed);
    end

    // R6 R8: transparent mode
    write_commit(8'h5A, 3, "R6 setup");
    cs_n = 1'b0; wr_n = 1'b0; data = 8'hC3; cyc(DCYC + 6);
    chk("R6 direct follows data", 8'hC3);
    data = 8'h81; cyc(3);
    chk("R6 direct tracks change", 8'h81);
    data = 8'h7E; cyc(3);
    chk("R6 direct tracks second change", 8'h7E);
    wr_n = 1'b1; cyc(4);
    chk("R8 exit shows output register", 8'h5A);
    cs_n = 1'b1; cyc(5);
    committed = 8'h7E;
    chk("R5 commit after direct", 8'h7E);

    // R8: leave by raising chip select first
    cs_n = 1'b0; wr_n = 1'b0; data = 8'h11; cyc(DCYC + 6);
    chk("R6 direct again", 8'h11);
    cs_n = 1'b1; cyc(5);
    committed = 8'h11;
    chk("R8 exit via cs commits bus", 8'h11);
    wr_n = 1'b1; cyc(3);

    // R9: immediate disable
    write_commit(8'hFF, 3, "R9 setup");
    dis_n = 1'b0; #1;
    chk("R9 outputs off without clock", '0);
    cyc(3);
    chk("R9 outputs off held", '0);
    dis_n = 1'b1; cyc(6);
    committed = '0;
    chk("R10 off after release", '0);
    cs_n = 1'b0; cyc(3); cs_n = 1'b1; cyc(5);
    chk("R10 bare cs pulse commits zero", '0);
    write_commit(8'h3C, 3, "R10 fresh write");

    // R9: disable clears a staged but uncommitted value
    cs_n = 1'b0; cyc(2); data = 8'hA5; wr_n = 1'b0; cyc(3); wr_n = 1'b1; cyc(3);
    dis_n = 1'b0; #1;
    chk("R9 off during staged write", '0);
    cyc(2); dis_n = 1'b1; cyc(6);
    cs_n = 1'b1; cyc(5);
    committed = '0;
    chk("R9 staged value cleared", '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule